// File: doc/BRIEF.md
# Dual-Convention Host Bus Bridge

This block lets an external processor reach an on-chip register file over a parallel host bus: an 8-bit address, a 16-bit data path, an active-low chip select, one shared strobe pin, one direction pin and one handshake pin. A static convention pin decides what those three pins mean. With the pin high, the strobe is an active-low data strobe, the direction pin is a read/write line (high reads, low writes) and the handshake pin is an active-low acknowledge. With the pin low, the strobe is an active-low read strobe, the direction pin is an active-low write strobe and the handshake pin is an active-high ready.

The host's asynchronous strobes are brought into the host-port clock domain by a two-flop synchronizer, and an access begins on the first synchronized active level. The block then reads or writes the register file through a synchronous internal port and raises the handshake. It drops the handshake at once when the host releases its strobe. A byte-wide mode lets an 8-bit host reach 16-bit registers in two byte cycles. A holding register collects the low byte, and the register is written only on the high-byte cycle.

The data bus is brought out as a pad-side split (input, output, output enable) so that the three-state driver sits in the pad ring. The enable is raised only for a read, while chip select and the read strobe are both active and the read data is valid.

Top module: `hostbus_bridge`

## Requirements
- R1: While reset is held, the handshake is inactive (1 with the convention pin high, 0 with it low), the data output enable is 0 and no register write is issued.
- R2: With chip select high, strobe activity starts no access: there is no register write, the handshake stays inactive and the output enable stays 0.
- R3: With the convention pin at 1, a low strobe starts an access. The direction pin at 1 makes it a read and at 0 a write, and the handshake pin goes low to acknowledge.
- R4: With the convention pin at 0, a low strobe is a read and a low direction pin is a write, and the handshake pin goes high for ready.
- R5: If the strobe is asserted just after a falling clock edge, the handshake is inactive through the third rising edge that follows and is active after the fourth. It goes inactive in the same cycle that the strobe, or chip select, is released.
- R6: In 16-bit mode, a write issues one register write with the register address equal to the host address and the data equal to the host data.
- R7: In 16-bit mode, a read returns the register at the host address on the data output. The output enable is 1 only while chip select is low, a read strobe is active and the handshake is active, and it is 0 during writes.
- R8: In byte mode, a write with address bit 0 at 0 keeps data bits 7:0 in a holding register and issues no register write. A write with bit 0 at 1 writes the register numbered by address bits 7:1, with the new data bits 7:0 as the high byte and the held byte as the low byte.
- R9: In byte mode, a read returns on data bits 7:0 the low byte (address bit 0 = 0) or the high byte (address bit 0 = 1) of the register numbered by address bits 7:1, and data bits 15:8 are 0.
- R10: One access issues at most one register write, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_mode | input | 1 | Convention select: 1 = strobe plus read/write line, 0 = separate read and write strobes |
| host_byte_mode | input | 1 | 1 = 8-bit data width, 0 = 16-bit |
| host_cs_n | input | 1 | Active-low chip select |
| host_strb_n | input | 1 | Shared active-low strobe (data strobe or read strobe) |
| host_dir | input | 1 | Read/write line or active-low write strobe |
| host_addr | input | 8 | Host address |
| host_d_i | input | 16 | Data from the pad (host write data) |
| host_d_o | output | 16 | Data to the pad (read data) |
| host_d_oe | output | 1 | Pad output enable for the data bus |
| host_hs | output | 1 | Acknowledge (active low) or ready (active high) |
| reg_addr | output | 8 | Register file address |
| reg_we | output | 1 | Register file write pulse, one clock |
| reg_wdata | output | 16 | Register file write data |
| reg_rdata | input | 16 | Register file read data for reg_addr, same cycle |

## Verification
The embedded assertions check on every cycle the properties that hold regardless of the traffic. The output enable never rises without chip select or outside a read. A write pulse never repeats in the following cycle. The holding byte changes only on a low-byte write. The acknowledge phase is entered only from the single access cycle. The bench's scenarios are needed for the behaviour that depends on what the host does. These include the exact clock on which the handshake appears under each convention, its immediate release, the byte assembly across two separate cycles, and register contents read back after earlier writes. They also include the absence of any effect when chip select is high.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_ACK  = 2'd2
  } hbi_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic cs_n,
  input  logic strb_n,
  input  logic dir,
  output logic cap_o,
  output logic step_o,
  output logic acc_rd_o,
  output logic hs_act_o,
  output logic rd_drive_o
);
  logic act_raw, rd_strb_raw, act_s, prev_q, start;
  logic acc_rd_q, acc_rd_d;
  hbi_state_e state_q, state_d;

  // Raw request: any strobe of the selected convention, gated by chip select
  assign act_raw     = !cs_n && (mode ? !strb_n : (!strb_n || !dir));
  assign rd_strb_raw = !cs_n && !strb_n && (mode ? dir : 1'b1);

  hbi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_act_sync (
    .clk(clk), .rst_n(rst_n), .d(act_raw), .q(act_s)
  );

  assign start = act_s && !prev_q;
  assign cap_o = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d  = state_q;
    acc_rd_d = acc_rd_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_STEP;
        acc_rd_d = mode ? dir : !strb_n;
      end
      ST_STEP: state_d = ST_ACK;
      ST_ACK:  if (!act_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      acc_rd_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      acc_rd_q <= acc_rd_d;
      prev_q   <= act_s;
    end
  end

  assign step_o     = (state_q == ST_STEP);
  assign acc_rd_o   = acc_rd_q;
  assign hs_act_o   = (state_q == ST_ACK) && act_raw;
  assign rd_drive_o = (state_q == ST_ACK) && acc_rd_q && rd_strb_raw;

  // R5: the acknowledge phase is only ever entered from the access cycle
  a_r5_ack_from_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && $past(state_q) != ST_ACK) |-> $past(state_q) == ST_STEP);
endmodule

// File: rtl/hbi_datapath.sv
module hbi_datapath #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_i,
  input  logic          cap,
  input  logic          step,
  input  logic          acc_rd,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] rd_data
);
  localparam int BW = DW / 2;

  logic [AW-1:0] acc_addr_q, acc_addr_d;
  logic [DW-1:0] acc_wd_q, acc_wd_d;
  logic          acc_b8_q, acc_b8_d;
  logic [BW-1:0] hold_q, hold_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          lo_wr;
  logic [BW-1:0] rd_byte;

  assign lo_wr = step && !acc_rd && acc_b8_q && !acc_addr_q[0];

  always_comb begin
    acc_addr_d = acc_addr_q;
    acc_wd_d   = acc_wd_q;
    acc_b8_d   = acc_b8_q;
    hold_d     = hold_q;
    rd_d       = rd_q;
    if (cap) begin
      acc_addr_d = addr;
      acc_wd_d   = d_i;
      acc_b8_d   = byte_mode;
    end
    if (lo_wr)           hold_d = acc_wd_q[BW-1:0];
    if (step && acc_rd)  rd_d   = reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr_q <= '0;
      acc_wd_q   <= '0;
      acc_b8_q   <= 1'b0;
      hold_q     <= '0;
      rd_q       <= '0;
    end else begin
      acc_addr_q <= acc_addr_d;
      acc_wd_q   <= acc_wd_d;
      acc_b8_q   <= acc_b8_d;
      hold_q     <= hold_d;
      rd_q       <= rd_d;
    end
  end

  assign reg_we    = step && !acc_rd && (!acc_b8_q || acc_addr_q[0]);
  assign reg_addr  = acc_b8_q ? {1'b0, acc_addr_q[AW-1:1]} : acc_addr_q;
  assign reg_wdata = acc_b8_q ? {acc_wd_q[BW-1:0], hold_q} : acc_wd_q;
  assign rd_byte   = acc_addr_q[0] ? rd_q[DW-1:BW] : rd_q[BW-1:0];
  assign rd_data   = acc_b8_q ? {{(DW-BW){1'b0}}, rd_byte} : rd_q;

  // R10: a register write is a single-cycle pulse per access
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R8: the held byte changes only on a low-byte write cycle
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> $stable(hold_q));
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_mode,
  input  logic          host_byte_mode,
  input  logic          host_cs_n,
  input  logic          host_strb_n,
  input  logic          host_dir,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe,
  output logic          host_hs,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  logic rst_q;
  logic cap, step, acc_rd, hs_act, rd_drive;

  // Asynchronous assertion, synchronous release
  hbi_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  hbi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_q), .mode(host_mode), .cs_n(host_cs_n),
    .strb_n(host_strb_n), .dir(host_dir), .cap_o(cap), .step_o(step),
    .acc_rd_o(acc_rd), .hs_act_o(hs_act), .rd_drive_o(rd_drive)
  );

  hbi_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_q), .byte_mode(host_byte_mode), .addr(host_addr),
    .d_i(host_d_i), .cap(cap), .step(step), .acc_rd(acc_rd),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rd_data(host_d_o)
  );

  assign host_d_oe = rd_drive;
  assign host_hs   = host_mode ? !hs_act : hs_act;

  // R7: the pad driver is never enabled without chip select
  a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_q)
    host_d_oe |-> !host_cs_n);
  // R7: the pad driver is only enabled for a read access
  a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_q)
    host_d_oe |-> acc_rd);
endmodule

// File: tb/hostbus_bridge_test.sv
module hostbus_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_mode, host_byte_mode, host_cs_n, host_strb_n, host_dir;
  logic [7:0]  host_addr;
  logic [15:0] host_d_i, host_d_o;
  logic        host_d_oe, host_hs;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata, reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hostbus_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .host_byte_mode(host_byte_mode),
    .host_cs_n(host_cs_n), .host_strb_n(host_strb_n), .host_dir(host_dir),
    .host_addr(host_addr), .host_d_i(host_d_i), .host_d_o(host_d_o),
    .host_d_oe(host_d_oe), .host_hs(host_hs), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Register file model outside the block
  logic [15:0] rf [16];
  int          we_cnt;
  logic [7:0]  last_wa;
  logic [15:0] last_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) rf[k] <= 16'h0000;
      we_cnt <= 0;
      last_wa <= 8'h00;
      last_wd <= 16'h0000;
    end else if (reg_we) begin
      rf[reg_addr[3:0]] <= reg_wdata;
      we_cnt  <= we_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= reg_wdata;
    end
  end
  assign reg_rdata = rf[reg_addr[3:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {mode, byte, rd, we, addr[8], data[16], expect[16]}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h03, 16'hA5C3, 16'hA5C3},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 16'h0000, 16'hA5C3},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 16'h1234, 16'h1234},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 16'h0000, 16'h1234},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h0C, 16'h00EF, 16'h0000},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h0D, 16'h00BE, 16'hBEEF},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h0C, 16'h0000, 16'h00EF},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h0D, 16'h0000, 16'h00BE},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h06, 16'h0000, 16'hBEEF},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 16'h0000, 16'hA5C3}
  };

  task automatic run_acc(input bit m, input bit b8, input bit rd, input bit we_exp,
                         input logic [7:0] a, input logic [15:0] d, input logic [15:0] exp);
    int         wc0;
    logic       hs_on;
    logic [7:0] ea;
    string      conv;
    hs_on = m ? 1'b0 : 1'b1;
    ea    = b8 ? {1'b0, a[7:1]} : a;
    conv  = m ? "R3" : "R4";
    @(negedge clk);
    host_mode = m; host_byte_mode = b8; host_addr = a; host_d_i = d;
    host_cs_n = 1'b0;
    host_strb_n = m ? 1'b0 : !rd;
    host_dir    = rd;
    wc0 = we_cnt;
    repeat (3) @(negedge clk);
    chk(host_hs != hs_on, "R5", "handshake before fourth edge", 32'(host_hs), 32'(!hs_on));
    @(negedge clk);
    chk(host_hs == hs_on, conv, "handshake level", 32'(host_hs), 32'(hs_on));
    if (rd) chk(host_d_oe && host_d_o == exp, b8 ? "R9" : "R7", "read data",
                {15'h0, host_d_oe, host_d_o}, {16'h1, exp});
    else    chk(!host_d_oe, "R7", "no drive on write", 32'(host_d_oe), 32'h0);
    repeat (2) @(negedge clk);
    chk(we_cnt - wc0 == int'(we_exp), b8 ? "R8" : "R10", "write count",
        32'(we_cnt - wc0), 32'(we_exp));
    if (we_exp) chk(last_wa == ea && last_wd == exp, b8 ? "R8" : "R6", "write addr/data",
                    {8'h0, last_wa, last_wd}, {8'h0, ea, exp});
    host_strb_n = 1'b1;
    host_dir    = 1'b1;
    #1;
    chk(host_hs != hs_on && !host_d_oe, "R5", "release on strobe",
        {host_hs, host_d_oe}, {!hs_on, 1'b0});
    @(negedge clk);
    host_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int wc0;
    rst_n = 1'b0; host_mode = 1'b1; host_byte_mode = 1'b0; host_cs_n = 1'b1;
    host_strb_n = 1'b1; host_dir = 1'b1; host_addr = 8'h00; host_d_i = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state under both conventions
    chk(host_hs == 1'b1 && !host_d_oe && !reg_we, "R1", "reset mode1",
        {host_hs, host_d_oe, reg_we}, 3'b100);
    host_mode = 1'b0;
    #1;
    chk(host_hs == 1'b0 && !host_d_oe, "R1", "reset mode0", {host_hs, host_d_oe}, 2'b00);
    host_mode = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      run_acc(v[43], v[42], v[41], v[40], v[39:32], v[31:16], v[15:0]);
    end

    // R2: strobes with chip select high have no effect
    wc0 = we_cnt;
    host_mode = 1'b1; host_byte_mode = 1'b0; host_addr = 8'h03; host_d_i = 16'hFFFF;
    host_dir = 1'b0; host_strb_n = 1'b0;
    repeat (8) begin
      @(negedge clk);
      chk(host_hs == 1'b1 && !host_d_oe, "R2", "idle with cs high",
          {host_hs, host_d_oe}, 2'b10);
    end
    host_strb_n = 1'b1; host_dir = 1'b1;
    repeat (4) @(negedge clk);
    chk(we_cnt == wc0, "R2", "no write with cs high", 32'(we_cnt), 32'(wc0));
    run_acc(1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 16'h0000, 16'hA5C3);

    // R7: chip select released mid-read drops the driver at once
    @(negedge clk);
    host_mode = 1'b1; host_byte_mode = 1'b0; host_addr = 8'h05;
    host_cs_n = 1'b0; host_dir = 1'b1; host_strb_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(host_d_oe && host_d_o == 16'h1234, "R7", "read before cs release",
        {15'h0, host_d_oe, host_d_o}, {16'h1, 16'h1234});
    host_cs_n = 1'b1;
    #1;
    chk(!host_d_oe && host_hs == 1'b1, "R7", "cs release stops drive",
        {host_d_oe, host_hs}, 2'b01);
    @(negedge clk) host_strb_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule